// File: doc/BRIEF.md
# Asynchronous DRAM Controller

This block sits between a host and an array of asynchronous page-mode DRAM whose row and column addresses share one set of pins. After reset it waits with both address strobes idle for a long settling pause. It then issues eight warm-up refreshes in which the column strobe leads the row strobe, so the part's own refresh counter supplies the row. Only after that does it open its host port. In normal operation it serves single-word reads and writes, and it interleaves periodic refreshes of the same kind. Each interval in the sequence is a parameter counted in controller clocks. The pause length is given in microseconds together with the clock rate.

The host issues a request on a valid/ready port: address, write flag and write data. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the host holds the request steady. `req_ready` is high only when the controller is idle, initialized and has no refresh waiting. A request that arrives while a refresh is pending therefore waits behind it. A refresh never breaks into a host cycle that has already started. Read data returns on a one-cycle `rsp_valid` pulse. This response path has no back-pressure, and the host must take it on that cycle.

Every write is an early write: the write strobe falls before the column strobe. The output enable stays high for the whole cycle, so the memory never drives its data pins while the controller drives them.

Top module: `adram_ctrl`

## Requirements
- R1: For the first PAUSE_US*CLK_MHZ cycles after reset is released, `ras_n` and `cas_n` both stay high. During reset, `ras_n`, `cas_n`, `we_n` and `oe_n` are high, and `req_ready`, `rsp_valid` and `dq_oe` are low.
- R2: `req_ready` never rises until at least eight refresh cycles have been issued after the pause.
- R3: In every refresh, `cas_n` is already low in the cycle before `ras_n` falls, and `mem_addr` is all zeros when `ras_n` falls.
- R4: In a host cycle, `mem_addr` carries the row half of `req_addr` (upper AW bits) when `ras_n` falls and holds it for T_RAH cycles. It then carries the column half (lower AW bits). `cas_n` falls no sooner than T_RAH+T_ASC cycles after `ras_n`.
- R5: In a write, `we_n` is already low in the cycle before `cas_n` falls, `dq_oe` is high when `cas_n` falls, and `oe_n` is high in every cycle where `we_n` is low.
- R6: In a read, `oe_n` is low while `cas_n` is low. `dq_in` is sampled on the last of T_CAC low cycles of `cas_n`, and it is returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle, the first cycle after `cas_n` rises.
- R7: A read ends with `ras_n` and `cas_n` rising together, and `we_n` stays high.
- R8: Once initialization is done, the gap between the starts of consecutive refreshes never exceeds REF_INT plus the longest host cycle and refresh lead-in.
- R9: `ras_n` is high for at least T_RP cycles before every falling edge.
- R10: On an edge where `req_valid` and `req_ready` are both high, the request is taken. `ras_n` is low in the next cycle, and `req_ready` is low whenever either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*AW | Word address: row in the upper half, column in the lower half |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | DW | Read data |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| mem_addr | output | AW | Multiplexed row/column address |
| dq_out | output | DW | Data driven toward the memory |
| dq_oe | output | 1 | 1 = controller drives the data pins |
| dq_in | input | DW | Data returned by the memory |

## Verification
A sequencer stuck in the wrong state or with a wrong count shows up at the ports within one memory cycle. The symptoms are a strobe edge that comes early, a refresh that does not lead with the column strobe, or a read pulse on the wrong cycle. A fault in the address mux or the request latch does not show until the word is read back. The bench catches it by comparing every read against a value computed from the address. A miscounted refresh timer shows only as a gap between refreshes that is too long. The bench measures every such gap.

// File: rtl/adram_pkg.sv
package adram_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_RCAS,
    ST_RRAS,
    ST_PRE,
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_CAS
  } adram_st_e;
endpackage

// File: rtl/adram_refresh_timer.sv
module adram_refresh_timer #(
  parameter int REF_INT = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic pend
);
  localparam int TW = (REF_INT > 1) ? $clog2(REF_INT) : 1;

  logic [TW-1:0] tcnt;
  logic          wrap;

  assign wrap = (tcnt == TW'(REF_INT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
      pend <= 1'b0;
    end else begin
      tcnt <= wrap ? '0 : tcnt + 1'b1;
      if (take) pend <= 1'b0;
      if (wrap) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/adram_seq.sv
module adram_seq
  import adram_pkg::*;
#(
  parameter int PAUSE_CYC = 10000,
  parameter int INIT_CYC  = 8,
  parameter int T_CSR     = 2,
  parameter int T_RASR    = 4,
  parameter int T_RP      = 3,
  parameter int T_RAH     = 1,
  parameter int T_ASC     = 1,
  parameter int T_CAC     = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_pend,
  input  logic      req_valid,
  input  logic      cyc_we,
  output adram_st_e st,
  output logic      ref_take,
  output logic      accept,
  output logic      cap_en,
  output logic      req_ready,
  output logic      ras_n,
  output logic      cas_n,
  output logic      we_n,
  output logic      oe_n,
  output logic      dq_oe
);
  localparam int M1   = (T_CSR > T_RASR) ? T_CSR : T_RASR;
  localparam int M2   = (T_RP > T_RAH) ? T_RP : T_RAH;
  localparam int M3   = (T_ASC > T_CAC) ? T_ASC : T_CAC;
  localparam int M4   = (M1 > M2) ? M1 : M2;
  localparam int M5   = (M3 > M4) ? M3 : M4;
  localparam int MAXT = (PAUSE_CYC > M5) ? PAUSE_CYC : M5;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int IW   = $clog2(INIT_CYC + 1);

  adram_st_e       st_nx;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   ld_val;
  logic            load;
  logic [IW-1:0]   init_left;
  logic            done;

  assign done = (cnt == '0);

  always_comb begin
    st_nx    = st;
    load     = 1'b0;
    ld_val   = '0;
    ref_take = 1'b0;
    accept   = 1'b0;
    cap_en   = 1'b0;
    unique case (st)
      ST_PAUSE: if (done) begin
        st_nx = ST_RCAS; load = 1'b1; ld_val = CW'(T_CSR - 1); ref_take = 1'b1;
      end
      ST_RCAS: if (done) begin
        st_nx = ST_RRAS; load = 1'b1; ld_val = CW'(T_RASR - 1);
      end
      ST_RRAS: if (done) begin
        st_nx = ST_PRE; load = 1'b1; ld_val = CW'(T_RP - 1);
      end
      ST_PRE: if (done) begin
        if (init_left != '0) begin
          st_nx = ST_RCAS; load = 1'b1; ld_val = CW'(T_CSR - 1); ref_take = 1'b1;
        end else begin
          st_nx = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (ref_pend) begin
          st_nx = ST_RCAS; load = 1'b1; ld_val = CW'(T_CSR - 1); ref_take = 1'b1;
        end else if (req_valid) begin
          st_nx = ST_ROW; load = 1'b1; ld_val = CW'(T_RAH - 1); accept = 1'b1;
        end
      end
      ST_ROW: if (done) begin
        st_nx = ST_COL; load = 1'b1; ld_val = CW'(T_ASC - 1);
      end
      ST_COL: if (done) begin
        st_nx = ST_CAS; load = 1'b1; ld_val = CW'(T_CAC - 1);
      end
      ST_CAS: if (done) begin
        st_nx = ST_PRE; load = 1'b1; ld_val = CW'(T_RP - 1); cap_en = !cyc_we;
      end
      default: st_nx = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_PAUSE;
      cnt       <= CW'(PAUSE_CYC - 1);
      init_left <= IW'(INIT_CYC);
    end else begin
      st <= st_nx;
      if (load)            cnt <= ld_val;
      else if (!done)      cnt <= cnt - 1'b1;
      if (ref_take && init_left != '0) init_left <= init_left - 1'b1;
    end
  end

  assign req_ready = (st == ST_IDLE) && !ref_pend;
  assign ras_n     = !(st inside {ST_RRAS, ST_ROW, ST_COL, ST_CAS});
  assign cas_n     = !(st inside {ST_RCAS, ST_RRAS, ST_CAS});
  assign we_n      = !(cyc_we && (st inside {ST_COL, ST_CAS}));
  assign oe_n      = !(!cyc_we && (st == ST_CAS));
  assign dq_oe     = cyc_we && (st inside {ST_COL, ST_CAS});
endmodule

// File: rtl/adram_datapath.sv
module adram_datapath
  import adram_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  adram_st_e       st,
  input  logic            accept,
  input  logic            cap_en,
  input  logic [2*AW-1:0] req_addr,
  input  logic            req_we,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW-1:0]   dq_in,
  output logic            cyc_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   dq_out,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata
);
  logic [AW-1:0] row_q;
  logic [AW-1:0] col_q;
  logic [DW-1:0] wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q     <= '0;
      col_q     <= '0;
      wd_q      <= '0;
      cyc_we    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        row_q  <= req_addr[2*AW-1:AW];
        col_q  <= req_addr[AW-1:0];
        wd_q   <= req_wdata;
        cyc_we <= req_we;
      end
      rsp_valid <= cap_en;
      if (cap_en) rsp_rdata <= dq_in;
    end
  end

  always_comb begin
    unique case (st)
      ST_ROW:         mem_addr = row_q;
      ST_COL, ST_CAS: mem_addr = col_q;
      default:        mem_addr = '0;
    endcase
  end

  assign dq_out = wd_q;
endmodule

// File: rtl/adram_ctrl.sv
module adram_ctrl
  import adram_pkg::*;
#(
  parameter int AW       = 10,
  parameter int DW       = 16,
  parameter int CLK_MHZ  = 50,
  parameter int PAUSE_US = 200,
  parameter int INIT_CYC = 8,
  parameter int REF_INT  = 780,
  parameter int T_CSR    = 2,
  parameter int T_RASR   = 4,
  parameter int T_RP     = 3,
  parameter int T_RAH    = 1,
  parameter int T_ASC    = 1,
  parameter int T_CAC    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_we,
  input  logic [2*AW-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic            oe_n,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe,
  input  logic [DW-1:0]   dq_in
);
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;

  adram_st_e st;
  logic      ref_pend, ref_take, accept, cap_en, cyc_we;

  adram_refresh_timer #(.REF_INT(REF_INT)) u_timer (
    .clk(clk), .rst_n(rst_n), .take(ref_take), .pend(ref_pend)
  );

  adram_seq #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_CYC(INIT_CYC), .T_CSR(T_CSR), .T_RASR(T_RASR),
    .T_RP(T_RP), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_CAC(T_CAC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ref_pend(ref_pend), .req_valid(req_valid),
    .cyc_we(cyc_we), .st(st), .ref_take(ref_take), .accept(accept),
    .cap_en(cap_en), .req_ready(req_ready), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe)
  );

  adram_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .accept(accept), .cap_en(cap_en),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .dq_in(dq_in),
    .cyc_we(cyc_we), .mem_addr(mem_addr), .dq_out(dq_out),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/adram_ctrl_chk.sv
module adram_ctrl_chk #(
  parameter int AW        = 10,
  parameter int PAUSE_CYC = 10000,
  parameter int INIT_CYC  = 8,
  parameter int REF_INT   = 780,
  parameter int T_CSR     = 2,
  parameter int T_RP      = 3,
  parameter int T_RAH     = 1,
  parameter int T_ASC     = 1,
  parameter int T_CAC     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic [AW-1:0] mem_addr
);
  localparam logic [31:0] SLACK = 32'(T_RAH + T_ASC + T_CAC + T_RP + T_CSR + 4);

  logic        ras_q, cas_q, we_q, oe_q;
  logic [31:0] since, lo, hi, gap, inits;
  logic        cbr_start, host_cas_fall;

  assign cbr_start     = ras_q && !ras_n && !cas_n;
  assign host_cas_fall = cas_q && !cas_n && !ras_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1; cas_q <= 1'b1; we_q <= 1'b1; oe_q <= 1'b1;
      since <= '0; lo <= '0; hi <= '0; gap <= '0; inits <= '0;
    end else begin
      ras_q <= ras_n; cas_q <= cas_n; we_q <= we_n; oe_q <= oe_n;
      if (since != 32'hFFFF_FFFF) since <= since + 1;
      lo  <= ras_n ? '0 : lo + 1;
      hi  <= ras_n ? ((hi != 32'hFFFF_FFFF) ? hi + 1 : hi) : '0;
      gap <= cbr_start ? 32'd1 : ((gap != 32'hFFFF_FFFF) ? gap + 1 : gap);
      if (cbr_start && inits != 32'hFFFF_FFFF) inits <= inits + 1;
    end
  end

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since < 32'(PAUSE_CYC)) |-> (ras_n && cas_n)); // R1
  AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (inits >= 32'(INIT_CYC))); // R2
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_start |-> (!cas_q && mem_addr == '0)); // R3
  AST_RCD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    host_cas_fall |-> (lo >= 32'(T_RAH + T_ASC))); // R4
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cas_n && lo > 0 && lo < 32'(T_RAH)) |-> $stable(mem_addr)); // R4
  AST_EARLY_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cas_fall && !we_n) |-> (!we_q && dq_oe && oe_n)); // R5
  AST_WRITE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n); // R5
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_RSP_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cas_n && !cas_q && !oe_q)); // R6
  AST_READ_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n && !cas_q && !oe_q) |-> (ras_n && we_n)); // R7
  AST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inits >= 32'(INIT_CYC + 1)) |-> (gap <= 32'(REF_INT) + SLACK)); // R8
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && !ras_n) |-> (hi >= 32'(T_RP))); // R9
  AST_ACCEPT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !ras_n); // R10
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && cas_n)); // R10
endmodule

bind adram_ctrl adram_ctrl_chk #(
  .AW(AW), .PAUSE_CYC(PAUSE_US * CLK_MHZ), .INIT_CYC(INIT_CYC), .REF_INT(REF_INT),
  .T_CSR(T_CSR), .T_RP(T_RP), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_CAC(T_CAC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
  .dq_oe(dq_oe), .mem_addr(mem_addr)
);

// File: tb/tb_adram_ctrl.sv
module tb_adram_ctrl;
  localparam int AW = 3, DW = 8, CLK_MHZ = 50, PAUSE_US = 1, INIT_CYC = 8;
  localparam int REF_INT = 60, T_CSR = 2, T_RASR = 3, T_RP = 2;
  localparam int T_RAH = 2, T_ASC = 1, T_CAC = 3;
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int SLACK = T_RAH + T_ASC + T_CAC + T_RP + T_CSR + 4;
  localparam int NW = 1 << (2 * AW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [2*AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rsp_rdata, dq_out, dq_in;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  adram_ctrl #(
    .AW(AW), .DW(DW), .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .INIT_CYC(INIT_CYC),
    .REF_INT(REF_INT), .T_CSR(T_CSR), .T_RASR(T_RASR), .T_RP(T_RP),
    .T_RAH(T_RAH), .T_ASC(T_ASC), .T_CAC(T_CAC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .mem_addr(mem_addr), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // memory model
  logic [DW-1:0] mem [NW];
  logic [AW-1:0] m_row, m_col;
  logic [2*AW-1:0] cur_addr;
  assign dq_in = (!cas_n && !oe_n) ? mem[{m_row, m_col}] : '0;

  int cyc = 0, refcnt = 0, last_ref = 0, lo = 0, hi = 0, since_cas = 99;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_rsp = 1'b0, ready_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc < PAUSE_CYC) chk(ras_n && cas_n, "R1 pause strobes", {ras_n, cas_n}, 3);
      if (!we_n) chk(oe_n, "R5 oe_n high during write", oe_n, 1);
      if (!ras_n || !cas_n) chk(!req_ready, "R10 ready low in cycle", req_ready, 0);
      if (req_ready && !ready_seen) begin
        ready_seen = 1'b1;
        chk(refcnt >= INIT_CYC, "R2 init refreshes before ready", refcnt, INIT_CYC);
      end
      if (p_ras && !ras_n) begin
        chk(hi >= T_RP, "R9 precharge", hi, T_RP);
        if (!cas_n) begin
          refcnt++;
          chk(!p_cas, "R3 cas leads ras", p_cas, 0);
          chk(mem_addr == '0, "R3 no address in refresh", mem_addr, 0);
          if (refcnt > INIT_CYC + 1)
            chk(cyc - last_ref <= REF_INT + SLACK, "R8 refresh gap", cyc - last_ref, REF_INT + SLACK);
          last_ref = cyc;
        end else begin
          m_row = mem_addr;
          chk(mem_addr == cur_addr[2*AW-1:AW], "R4 row address", mem_addr, cur_addr[2*AW-1:AW]);
        end
      end
      if (!ras_n && cas_n && lo > 0 && lo < T_RAH)
        chk(mem_addr == cur_addr[2*AW-1:AW], "R4 row hold", mem_addr, cur_addr[2*AW-1:AW]);
      if (p_cas && !cas_n && !ras_n) begin
        chk(lo >= T_RAH + T_ASC, "R4 ras to cas", lo, T_RAH + T_ASC);
        chk(mem_addr == cur_addr[AW-1:0], "R4 column address", mem_addr, cur_addr[AW-1:0]);
        m_col = mem_addr;
        if (!we_n) begin
          chk(!p_we && dq_oe && oe_n, "R5 early write", {p_we, dq_oe, oe_n}, 3'b011);
          mem[{m_row, mem_addr}] = dq_out;
        end else begin
          chk(!oe_n, "R6 oe_n low in read", oe_n, 0);
          since_cas = 0;
        end
      end else if (since_cas < 99) since_cas++;
      if (since_cas == T_CAC) begin
        chk(rsp_valid, "R6 response timing", rsp_valid, 1);
        chk(ras_n && cas_n && we_n, "R7 read end", {ras_n, cas_n, we_n}, 7);
      end
      if (p_rsp) chk(!rsp_valid, "R6 one-cycle pulse", rsp_valid, 0);
      lo = ras_n ? 0 : lo + 1;
      hi = ras_n ? hi + 1 : 0;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_rsp = rsp_valid;
      cyc++;
      if (cyc == 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input int pass);
    return DW'(a * 29 + pass * 71 + 3);
  endfunction

  task automatic xfer(input int a, input bit w, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_we = w; req_wdata = d;
    req_addr = (2*AW)'(a); cur_addr = (2*AW)'(a);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!ras_n && !req_ready, "R10 accept opens row", {ras_n, req_ready}, 0);
    rd = '0;
    if (!w) begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata;
    end else begin
      while (!ras_n) @(negedge clk);
    end
  endtask

  initial begin
    logic [DW-1:0] rd;
    for (int i = 0; i < NW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 reset strobes", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!req_ready && !rsp_valid && !dq_oe, "R1 reset outputs", {req_ready, rsp_valid, dq_oe}, 0);
    rst_n = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < NW; a++) xfer(a, 1'b1, pat(a, pass), rd);
      for (int a = NW - 1; a >= 0; a--) begin
        xfer(a, 1'b0, '0, rd);
        chk(rd == pat(a, pass), "R6 read data", rd, pat(a, pass));
      end
    end
    for (int a = 0; a < NW; a++) begin
      xfer(a, 1'b1, pat(a, 5), rd);
      xfer(a, 1'b0, '0, rd);
      chk(rd == pat(a, 5), "R6 write-read pair", rd, pat(a, 5));
    end
    chk(refcnt > INIT_CYC + 10, "R8 refreshes continue", refcnt, INIT_CYC + 10);
    repeat (5) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule